// File: doc/BRIEF.md
# Banked Register-Set Select Register

This block is a 32-bit control and status word that tells a banked register file which physical copy of each working-register group is live. There are three independent 2-bit bank fields: one for the IY pair, one for the IX pair, and one for the main group (accumulator, flags, BC, DE, HL and their primed twins). There are also three primary/alternate select bits, one each for IY, IX and the BC/DE/HL group. Beside these the word carries an interrupt enable flag, a 2-bit interrupt mode field and a one-way extended-mode flag.

Software loads or reads the whole word. The instruction sequencer also sends single-cycle pulses for register exchange, entering extended mode, setting the interrupt mode, and enabling or disabling interrupts. The extended-mode flag is held by a two-state machine. `MODE_NATIVE` is the reset state. The transition `T_ENTER_EXT` fires on the set-extended-mode pulse and leads to `MODE_EXTENDED`. That state has only the self-transition `T_HOLD_EXT`, and only reset leaves it. Every field is also driven straight out as a decoded index for the register file.

Top module: `regset_select`

## Requirements
- R1: After reset every field is 0: all three banks are bank 0, all alternate bits select the primary copy, the block is in native mode, interrupts are disabled, interrupt mode is 0, and `rd_data` is 0.
- R2: A load (`load_en`=1) writes the fields from `load_data` at these positions, visible from the cycle after the edge: main bank [1:0], IX bank [3:2], IY bank [5:4], main alternate bit 8, IX alternate bit 9, IY alternate bit 10, interrupt enable bit 13, interrupt mode [17:16]. Each bank field takes its own slice and does not affect the others.
- R3: Every bit of `rd_data` other than the fields in R2 and the extended-mode bit 12 reads 0, whatever was loaded.
- R4: An exchange pulse without a load inverts the main alternate bit and leaves every other field unchanged.
- R5: When a load and an exchange pulse arrive in the same cycle, the loaded value wins. The same priority holds over the interrupt-mode, enable and disable pulses.
- R6: A set-extended-mode pulse makes bit 12 and `ext_mode` read 1 from the next cycle.
- R7: Once set, extended mode stays 1 until reset. A load with bit 12 at 0 does not clear it, and a load with bit 12 at 1 does not set it.
- R8: An interrupt-mode pulse without a load copies `im_val` into the interrupt mode field.
- R9: An enable pulse sets the interrupt enable bit and a disable pulse clears it. If both arrive together, the disable pulse wins.
- R10: The outputs `main_bank`, `ix_bank`, `iy_bank`, `main_alt`, `ix_alt`, `iy_alt`, `ext_mode`, `int_en` and `int_mode` always equal the matching fields of `rd_data` in the same cycle.
- R11: In a cycle with no load and no pulse, the word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Full-word load strobe |
| load_data | input | 32 | Word to load |
| xchg_pulse | input | 1 | Exchange: invert the main alternate bit |
| setxm_pulse | input | 1 | Enter extended mode |
| im_pulse | input | 1 | Write the interrupt mode |
| im_val | input | 2 | Interrupt mode value |
| ei_pulse | input | 1 | Enable interrupts |
| di_pulse | input | 1 | Disable interrupts |
| rd_data | output | 32 | Current word, reserved bits 0 |
| main_bank | output | 2 | Bank index for the main group |
| ix_bank | output | 2 | Bank index for IX/IX' |
| iy_bank | output | 2 | Bank index for IY/IY' |
| main_alt | output | 1 | 1 selects BC'/DE'/HL' |
| ix_alt | output | 1 | 1 selects IX' |
| iy_alt | output | 1 | 1 selects IY' |
| ext_mode | output | 1 | 1 in extended mode |
| int_en | output | 1 | Interrupt enable flag |
| int_mode | output | 2 | Interrupt mode |

## Verification
Directed cases cover the fixed points:
- Loading all ones separates the writable bits from the reserved ones.
- A load together with an exchange shows which source has priority.
- Enable and disable pulses in the same cycle show which one wins.
- Loads with bit 12 at 0 and at 1, before and after entering extended mode, show that the flag is one-way.

Random pulse sequences, mixed with occasional loads, then exercise toggle parity, the independence of the bank fields, and the agreement of the decoded outputs with the word. Each cycle of these sequences is compared against a bench model.

// File: rtl/regsel_pkg.sv
package regsel_pkg;
    localparam int WORD_W = 32;
    localparam int BANK_W = 2;
    localparam int IM_W   = 2;

    // Field positions inside the control word
    localparam int P_MAIN_BANK = 0;
    localparam int P_IX_BANK   = 2;
    localparam int P_IY_BANK   = 4;
    localparam int P_MAIN_ALT  = 8;
    localparam int P_IX_ALT    = 9;
    localparam int P_IY_ALT    = 10;
    localparam int P_XM        = 12;
    localparam int P_IE        = 13;
    localparam int P_IM        = 16;

    typedef enum logic {
        MODE_NATIVE   = 1'b0,
        MODE_EXTENDED = 1'b1
    } mode_e;

    typedef struct packed {
        logic [BANK_W-1:0] main_bank;
        logic [BANK_W-1:0] ix_bank;
        logic [BANK_W-1:0] iy_bank;
        logic              main_alt;
        logic              ix_alt;
        logic              iy_alt;
        logic              ie;
        logic [IM_W-1:0]   im;
    } fields_t;
endpackage

// File: rtl/regsel_mode_fsm.sv
module regsel_mode_fsm
    import regsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    output logic ext_mode
);
    mode_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_NATIVE;
        else        state_q <= state_d;
    end

    // Transitions: T_ENTER_EXT and T_HOLD_EXT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NATIVE:   if (set_pulse) state_d = MODE_EXTENDED;
            MODE_EXTENDED: state_d = MODE_EXTENDED;
        endcase
    end

    // Outputs
    always_comb begin
        ext_mode = (state_q == MODE_EXTENDED);
    end

    a_r6_enter_ext: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> ext_mode);
    a_r7_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |=> ext_mode);
endmodule

// File: rtl/regsel_fields.sv
module regsel_fields
    import regsel_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [W-1:0]    load_data,
    input  logic            xchg_pulse,
    input  logic            im_pulse,
    input  logic [IM_W-1:0] im_val,
    input  logic            ei_pulse,
    input  logic            di_pulse,
    output fields_t         fields
);
    fields_t q, d;

    always_comb begin
        d = q;
        if (load_en) begin
            d.main_bank = load_data[P_MAIN_BANK +: BANK_W];
            d.ix_bank   = load_data[P_IX_BANK +: BANK_W];
            d.iy_bank   = load_data[P_IY_BANK +: BANK_W];
            d.main_alt  = load_data[P_MAIN_ALT];
            d.ix_alt    = load_data[P_IX_ALT];
            d.iy_alt    = load_data[P_IY_ALT];
            d.ie        = load_data[P_IE];
            d.im        = load_data[P_IM +: IM_W];
        end else begin
            if (xchg_pulse) d.main_alt = ~q.main_alt;
            if (im_pulse)   d.im = im_val;
            if (di_pulse)      d.ie = 1'b0;
            else if (ei_pulse) d.ie = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fields = q;

    a_r4_exchange: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_pulse && !load_en) |=> (fields.main_alt != $past(fields.main_alt))
            && $stable(fields.main_bank) && $stable(fields.ix_bank)
            && $stable(fields.iy_bank) && $stable(fields.ix_alt) && $stable(fields.iy_alt));
    a_r5_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && xchg_pulse) |=> fields.main_alt == $past(load_data[P_MAIN_ALT]));
    a_r8_int_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (im_pulse && !load_en) |=> fields.im == $past(im_val));
    a_r9_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (di_pulse && !load_en) |=> !fields.ie);
    a_r9_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_pulse && !di_pulse && !load_en) |=> fields.ie);
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_en || xchg_pulse || im_pulse || ei_pulse || di_pulse) |=> $stable(fields));
endmodule

// File: rtl/regsel_decode.sv
module regsel_decode
    import regsel_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  fields_t           fields,
    input  logic              ext_in,
    output logic [W-1:0]      word,
    output logic [BANK_W-1:0] main_bank,
    output logic [BANK_W-1:0] ix_bank,
    output logic [BANK_W-1:0] iy_bank,
    output logic              main_alt,
    output logic              ix_alt,
    output logic              iy_alt,
    output logic              ext_mode,
    output logic              int_en,
    output logic [IM_W-1:0]   int_mode
);
    always_comb begin
        word = '0;
        word[P_MAIN_BANK +: BANK_W] = fields.main_bank;
        word[P_IX_BANK +: BANK_W]   = fields.ix_bank;
        word[P_IY_BANK +: BANK_W]   = fields.iy_bank;
        word[P_MAIN_ALT]            = fields.main_alt;
        word[P_IX_ALT]              = fields.ix_alt;
        word[P_IY_ALT]              = fields.iy_alt;
        word[P_XM]                  = ext_in;
        word[P_IE]                  = fields.ie;
        word[P_IM +: IM_W]          = fields.im;
    end

    assign main_bank = fields.main_bank;
    assign ix_bank   = fields.ix_bank;
    assign iy_bank   = fields.iy_bank;
    assign main_alt  = fields.main_alt;
    assign ix_alt    = fields.ix_alt;
    assign iy_alt    = fields.iy_alt;
    assign ext_mode  = ext_in;
    assign int_en    = fields.ie;
    assign int_mode  = fields.im;
endmodule

// File: rtl/regset_select.sv
module regset_select
    import regsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_data,
    input  logic              xchg_pulse,
    input  logic              setxm_pulse,
    input  logic              im_pulse,
    input  logic [IM_W-1:0]   im_val,
    input  logic              ei_pulse,
    input  logic              di_pulse,
    output logic [WORD_W-1:0] rd_data,
    output logic [BANK_W-1:0] main_bank,
    output logic [BANK_W-1:0] ix_bank,
    output logic [BANK_W-1:0] iy_bank,
    output logic              main_alt,
    output logic              ix_alt,
    output logic              iy_alt,
    output logic              ext_mode,
    output logic              int_en,
    output logic [IM_W-1:0]   int_mode
);
    fields_t fields;
    logic    ext_q;

    regsel_fields #(.W(WORD_W)) i_fields (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
        .xchg_pulse(xchg_pulse), .im_pulse(im_pulse), .im_val(im_val),
        .ei_pulse(ei_pulse), .di_pulse(di_pulse), .fields(fields)
    );

    regsel_mode_fsm i_mode (
        .clk(clk), .rst_n(rst_n), .set_pulse(setxm_pulse), .ext_mode(ext_q)
    );

    regsel_decode #(.W(WORD_W)) i_decode (
        .fields(fields), .ext_in(ext_q), .word(rd_data),
        .main_bank(main_bank), .ix_bank(ix_bank), .iy_bank(iy_bank),
        .main_alt(main_alt), .ix_alt(ix_alt), .iy_alt(iy_alt),
        .ext_mode(ext_mode), .int_en(int_en), .int_mode(int_mode)
    );

    a_r2_load_banks: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (main_bank == $past(load_data[P_MAIN_BANK +: BANK_W]))
            && (ix_bank == $past(load_data[P_IX_BANK +: BANK_W]))
            && (iy_bank == $past(load_data[P_IY_BANK +: BANK_W])));
    a_r7_load_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !setxm_pulse) |=> rd_data[P_XM] == $past(ext_mode));
endmodule

// File: tb/test_regset_select.sv
module test_regset_select;
    localparam int PERIOD = 10;
    localparam logic [31:0] RW_MASK = 32'h0003_273F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_en = 1'b0;
    logic [31:0] load_data = '0;
    logic xchg_pulse = 1'b0, setxm_pulse = 1'b0, im_pulse = 1'b0;
    logic [1:0] im_val = '0;
    logic ei_pulse = 1'b0, di_pulse = 1'b0;
    logic [31:0] rd_data;
    logic [1:0] main_bank, ix_bank, iy_bank, int_mode;
    logic main_alt, ix_alt, iy_alt, ext_mode, int_en;

    int total = 0;
    int bad = 0;
    logic [31:0] model = '0;

    always #(PERIOD/2) clk = ~clk;

    regset_select i_regset_select (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
        .xchg_pulse(xchg_pulse), .setxm_pulse(setxm_pulse), .im_pulse(im_pulse),
        .im_val(im_val), .ei_pulse(ei_pulse), .di_pulse(di_pulse),
        .rd_data(rd_data), .main_bank(main_bank), .ix_bank(ix_bank),
        .iy_bank(iy_bank), .main_alt(main_alt), .ix_alt(ix_alt), .iy_alt(iy_alt),
        .ext_mode(ext_mode), .int_en(int_en), .int_mode(int_mode)
    );

    function automatic logic [31:0] next_word(logic [31:0] cur, logic ld, logic [31:0] d,
        logic xc, logic sx, logic imp, logic [1:0] iv, logic ei, logic di);
        logic [31:0] n;
        if (ld) begin
            n = (d & RW_MASK) | (cur & 32'h0000_1000);
        end else begin
            n = cur;
            if (xc) n[8] = ~n[8];
            if (imp) n[17:16] = iv;
            if (di) n[13] = 1'b0;
            else if (ei) n[13] = 1'b1;
        end
        if (sx) n[12] = 1'b1;
        return n;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [31:0] dec;
        check(tag, rd_data, model);
        dec = '0;
        dec[1:0] = main_bank; dec[3:2] = ix_bank; dec[5:4] = iy_bank;
        dec[8] = main_alt; dec[9] = ix_alt; dec[10] = iy_alt;
        dec[12] = ext_mode; dec[13] = int_en; dec[17:16] = int_mode;
        check("R10", dec, rd_data);
    endtask

    task automatic cycle(logic ld, logic [31:0] d, logic xc, logic sx, logic imp,
        logic [1:0] iv, logic ei, logic di, string tag);
        @(negedge clk);
        load_en = ld; load_data = d; xchg_pulse = xc; setxm_pulse = sx;
        im_pulse = imp; im_val = iv; ei_pulse = ei; di_pulse = di;
        @(posedge clk);
        model = next_word(model, ld, d, xc, sx, imp, iv, ei, di);
        #1;
        check_all(tag);
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        string tag;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        model = '0;
        check_all("R1");

        // R3: reserved bits stay 0 after loading all ones
        cycle(1'b1, 32'hFFFF_FFFF, 0, 0, 0, 2'd0, 0, 0, "R3");
        // R2: distinct bank values stay independent
        cycle(1'b1, 32'h0000_0039, 0, 0, 0, 2'd0, 0, 0, "R2");
        check("R2", {30'd0, ix_bank}, 32'd2);
        // R5: load beats exchange, im, ei
        cycle(1'b1, 32'h0000_0000, 1, 0, 1, 2'd3, 1, 0, "R5");
        // R4: exchange toggles only the main alternate bit
        cycle(1'b0, '0, 1, 0, 0, 2'd0, 0, 0, "R4");
        cycle(1'b0, '0, 1, 0, 0, 2'd0, 0, 0, "R4");
        // R9: enable with disable together -> disabled
        cycle(1'b0, '0, 0, 0, 0, 2'd0, 1, 0, "R9");
        cycle(1'b0, '0, 0, 0, 0, 2'd0, 1, 1, "R9");
        // R8
        cycle(1'b0, '0, 0, 0, 1, 2'd2, 0, 0, "R8");
        // R7: load of bit 12 set in native mode does not set it
        cycle(1'b1, 32'h0000_1000, 0, 0, 0, 2'd0, 0, 0, "R7");
        check("R7", {31'd0, ext_mode}, 32'd0);
        // R6 then R7: cannot be cleared by load
        cycle(1'b0, '0, 0, 1, 0, 2'd0, 0, 0, "R6");
        cycle(1'b1, 32'h0000_0000, 0, 0, 0, 2'd0, 0, 0, "R7");
        check("R7", {31'd0, ext_mode}, 32'd1);
        // R11 idle
        cycle(1'b0, '0, 0, 0, 0, 2'd0, 0, 0, "R11");

        // Re-enter native mode through reset
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        model = '0;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 3000; i++) begin
            logic ld, xc, sx, imp, ei, di;
            logic [31:0] d;
            logic [1:0] iv;
            ld = ($urandom % 8) == 0;
            xc = ($urandom % 4) == 0;
            sx = ($urandom % 400) == 0;
            imp = ($urandom % 6) == 0;
            ei = ($urandom % 6) == 0;
            di = ($urandom % 6) == 0;
            d = $urandom;
            iv = 2'($urandom);
            if (ld && xc) tag = "R5";
            else if (ld) tag = "R2";
            else if (sx) tag = "R6";
            else if (xc) tag = "R4";
            else if (imp) tag = "R8";
            else if (ei || di) tag = "R9";
            else if (model[12]) tag = "R7";
            else tag = "R11";
            cycle(ld, d, xc, sx, imp, iv, ei, di, tag);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule